// File: doc/BRIEF.md
# Indirect Interrupt Controller Register File

This block holds the programmable state of an I/O interrupt controller. The CPU sees only two registers: an 8-bit index register and a 32-bit data window. A window access reads or writes the internal register that the index currently names. The internal registers are a controller identity, a fixed version word, an arbitration identity, and a table with one redirection entry for each interrupt input.

Each table entry takes two window words. One word holds the vector, the trigger sensitivity, a static or dynamic target-selection flag and a mask. The other word holds the destination. Every entry field is driven onto flat output buses for the dispatch logic. A write to the identity register also loads the arbitration identity, which the serial bus arbiter uses. The arbitration identity cannot be written in any other way.

Index map: 0x00 identity, 0x01 version, 0x02 arbitration identity, and 0x10 + 2·k / 0x11 + 2·k for the low and high words of entry k. `N_ENT` must be a power of two, and the table must fit below index 0x100.

Top module: `irq_regfile`

## Requirements
- R1: While reset is low and after it is released, the index is 0x00, the identity and arbitration identity are 0, and every entry reads low word 0x0001_0000 (mask set, all other fields 0) and high word 0.
- R2: A pulse on `sel_we` loads `sel_wdata` into the index, and the index appears on `cur_index` one clock later.
- R3: A window write at index 0x00 stores bits [27:24] as the identity. A read at 0x00 returns the identity in bits [27:24] and 0 in all other bits.
- R4: A window write at index 0x00 loads the same 4-bit value into the arbitration identity. That value appears on `arb_id` and in bits [27:24] of a read at 0x02.
- R5: A read at index 0x01 returns 0x000F_0011 with the default parameters: bits [7:0] hold the version 0x11 and bits [23:16] hold N_ENT−1. Writes at this index have no effect.
- R6: Window writes at index 0x02 do not change the arbitration identity.
- R7: The low word of entry k is laid out as bits [7:0] vector, bit 8 dynamic selection, bit 15 level trigger and bit 16 mask. Other bits are dropped on write and read as 0. The fields appear on the entry-k slices of `ent_vector`, `ent_dyn`, `ent_level` and `ent_mask`.
- R8: The high word of entry k holds the destination in bits [31:24]. Other bits read as 0. The destination appears on `ent_dest[8k+7:8k]`.
- R9: A read at an index outside the map (0x03–0x0F, 0x30–0xFF) returns 0. A write there changes no register.
- R10: When the index and the window are written in the same cycle, the window write uses the index held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Index register write strobe |
| sel_wdata | input | 8 | New index value |
| win_we | input | 1 | Window write strobe |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Window read data for the current index |
| cur_index | output | 8 | Current index |
| arb_id | output | 4 | Arbitration identity |
| ent_vector | output | 128 | Vector of each entry, 8 bits per entry |
| ent_level | output | 16 | Level-trigger flag of each entry |
| ent_dyn | output | 16 | Dynamic-selection flag of each entry |
| ent_mask | output | 16 | Mask flag of each entry |
| ent_dest | output | 128 | Destination of each entry, 8 bits per entry |

## Verification
The assertions assume that reads take no side effects, so `win_rdata` may be compared at any cycle against the index held in that cycle. They also assume the inputs are already synchronous to `clk`. The bench changes every input on the falling edge, so each strobe covers exactly one rising edge. It also sweeps every unmapped index and every table word, so each decode path of the index is exercised on both the read and the write side.

// File: rtl/irq_regfile.sv
module irq_regfile #(
  parameter int       N_ENT    = 16,
  parameter int       ID_W     = 4,
  parameter int       DEST_W   = 8,
  parameter logic [7:0] VERSION  = 8'h11,
  parameter logic [7:0] TBL_BASE = 8'h10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_we,
  input  logic [7:0]            sel_wdata,
  input  logic                  win_we,
  input  logic [31:0]           win_wdata,
  output logic [31:0]           win_rdata,
  output logic [7:0]            cur_index,
  output logic [ID_W-1:0]       arb_id,
  output logic [N_ENT*8-1:0]    ent_vector,
  output logic [N_ENT-1:0]      ent_level,
  output logic [N_ENT-1:0]      ent_dyn,
  output logic [N_ENT-1:0]      ent_mask,
  output logic [N_ENT*DEST_W-1:0] ent_dest
);
  localparam int EW = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam logic [7:0]  IDX_ID  = 8'h00;
  localparam logic [7:0]  IDX_VER = 8'h01;
  localparam logic [7:0]  IDX_ARB = 8'h02;
  localparam logic [31:0] VER_WORD = {8'h00, 8'(N_ENT - 1), 8'h00, VERSION};

  logic [7:0]      idx_q;
  logic [ID_W-1:0] id_q, arb_q;
  logic [7:0]      off;
  logic [EW-1:0]   sel;
  logic            hi, in_tbl, mapped;

  assign off    = idx_q - TBL_BASE;
  assign hi     = off[0];
  assign sel    = off[EW:1];
  assign in_tbl = (idx_q >= TBL_BASE) && (off[7:EW+1] == '0);
  assign mapped = in_tbl || idx_q == IDX_ID || idx_q == IDX_VER || idx_q == IDX_ARB;

  assign cur_index = idx_q;
  assign arb_id    = arb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      id_q  <= '0;
      arb_q <= '0;
    end else begin
      if (sel_we) idx_q <= sel_wdata;
      if (win_we && idx_q == IDX_ID) begin
        id_q  <= win_wdata[24 +: ID_W];
        arb_q <= win_wdata[24 +: ID_W];
      end
    end
  end

  logic [7:0]        vec_q [N_ENT];
  logic [DEST_W-1:0] dst_q [N_ENT];
  logic [N_ENT-1:0]  lvl_q, dyn_q, msk_q;

  for (genvar k = 0; k < N_ENT; k++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q[k] <= '0;
        dst_q[k] <= '0;
        lvl_q[k] <= 1'b0;
        dyn_q[k] <= 1'b0;
        msk_q[k] <= 1'b1;
      end else if (win_we && in_tbl && sel == EW'(k)) begin
        if (hi) begin
          dst_q[k] <= win_wdata[31 -: DEST_W];
        end else begin
          vec_q[k] <= win_wdata[7:0];
          dyn_q[k] <= win_wdata[8];
          lvl_q[k] <= win_wdata[15];
          msk_q[k] <= win_wdata[16];
        end
      end
    end
    assign ent_vector[k*8 +: 8]          = vec_q[k];
    assign ent_dest[k*DEST_W +: DEST_W]  = dst_q[k];
  end

  assign ent_level = lvl_q;
  assign ent_dyn   = dyn_q;
  assign ent_mask  = msk_q;

  always_comb begin
    win_rdata = '0;
    if (idx_q == IDX_ID)       win_rdata[24 +: ID_W] = id_q;
    else if (idx_q == IDX_VER) win_rdata = VER_WORD;
    else if (idx_q == IDX_ARB) win_rdata[24 +: ID_W] = arb_q;
    else if (in_tbl) begin
      if (hi) win_rdata[31 -: DEST_W] = dst_q[sel];
      else    win_rdata = {15'h0, msk_q[sel], lvl_q[sel], 6'h0, dyn_q[sel], vec_q[sel]};
    end
  end

  assert_arb_loads_from_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && cur_index == IDX_ID) |=> (arb_id == $past(win_wdata[24 +: ID_W])));

  assert_arb_only_via_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_we && cur_index == IDX_ID) |=> $stable(arb_id));

  assert_version_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_index == IDX_VER) |-> (win_rdata == VER_WORD));

  assert_unmapped_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (win_rdata == 32'h0));

  assert_unmapped_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && !mapped) |=> ($stable(ent_vector) && $stable(ent_dest) && $stable(ent_mask)
                             && $stable(ent_level) && $stable(ent_dyn) && $stable(arb_id)));

  assert_low_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tbl && !hi) |-> (win_rdata[31:17] == 15'h0 && win_rdata[14:9] == 6'h0));

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> (cur_index == $past(sel_wdata)));
endmodule

// File: tb/irq_regfile_bench.sv
module irq_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_we = 1'b0;
  logic [7:0] sel_wdata = '0;
  logic win_we = 1'b0;
  logic [31:0] win_wdata = '0;
  logic [31:0] win_rdata;
  logic [7:0] cur_index;
  logic [3:0] arb_id;
  logic [N*8-1:0] ent_vector, ent_dest;
  logic [N-1:0] ent_level, ent_dyn, ent_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_regfile u_irq_regfile (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .win_we(win_we), .win_wdata(win_wdata), .win_rdata(win_rdata),
    .cur_index(cur_index), .arb_id(arb_id), .ent_vector(ent_vector),
    .ent_level(ent_level), .ent_dyn(ent_dyn), .ent_mask(ent_mask), .ent_dest(ent_dest)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] v);
    @(negedge clk); sel_we = 1'b1; sel_wdata = v;
    @(negedge clk); sel_we = 1'b0;
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); win_we = 1'b1; win_wdata = v;
    @(negedge clk); win_we = 1'b0;
  endtask

  task automatic wr_at(input logic [7:0] i, input logic [31:0] v);
    set_idx(i); wr(v);
  endtask

  task automatic rd_at(input logic [7:0] i, output logic [31:0] v);
    set_idx(i); v = win_rdata;
  endtask

  function automatic logic [31:0] low_exp(input int k);
    logic [7:0] vec = 8'((k*37 + 5) & 255);
    return {15'h0, 1'(k >> 2), 1'(k >> 1), 6'h0, 1'(k), vec};
  endfunction

  function automatic logic [7:0] dst_exp(input int k);
    return 8'(255 - k*9);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    #(CLK_PERIOD * 2);
    // R1: reset state
    check("R1 index", {24'h0, cur_index}, 32'h0);
    check("R1 arb", {28'h0, arb_id}, 32'h0);
    check("R1 mask", {16'h0, ent_mask}, 32'h0000FFFF);
    @(negedge clk); rst_n = 1'b1;
    rd_at(8'h00, r); check("R1 id", r, 32'h0);
    rd_at(8'h02, r); check("R1 arb word", r, 32'h0);
    for (int k = 0; k < N; k++) begin
      rd_at(8'(16 + 2*k), r);     check("R1 low", r, 32'h0001_0000);
      rd_at(8'(16 + 2*k + 1), r); check("R1 high", r, 32'h0);
    end

    // R2: index register
    for (int i = 0; i < 256; i += 17) begin
      set_idx(8'(i)); check("R2 index", {24'h0, cur_index}, 32'(i));
    end

    // R3 / R4: identity and arbitration identity
    for (int v = 0; v < 16; v++) begin
      wr_at(8'h00, {4'hF, 4'(v), 24'hFFFFFF});
      check("R3 id", win_rdata, {4'h0, 4'(v), 24'h0});
      check("R4 arb port", {28'h0, arb_id}, 32'(v));
      rd_at(8'h02, r); check("R4 arb word", r, {4'h0, 4'(v), 24'h0});
    end

    // R5: version fixed
    rd_at(8'h01, r); check("R5 version", r, 32'h000F_0011);
    wr(32'hFFFF_FFFF); check("R5 version after write", win_rdata, 32'h000F_0011);

    // R6: arbitration identity not directly writable (currently 15)
    wr_at(8'h02, 32'h0300_0000);
    check("R6 arb word", win_rdata, 32'h0F00_0000);
    check("R6 arb port", {28'h0, arb_id}, 32'hF);

    // R7 / R8: table words
    for (int k = 0; k < N; k++) begin
      wr_at(8'(16 + 2*k), low_exp(k) | 32'hFFFE_7E00);
      wr_at(8'(16 + 2*k + 1), {dst_exp(k), 24'hFFFFFF});
    end
    for (int k = 0; k < N; k++) begin
      rd_at(8'(16 + 2*k), r);     check("R7 low", r, low_exp(k));
      rd_at(8'(16 + 2*k + 1), r); check("R8 high", r, {dst_exp(k), 24'h0});
      check("R7 vector port", {24'h0, ent_vector[k*8 +: 8]}, {24'h0, low_exp(k)[7:0]});
      check("R7 flag ports", {29'h0, ent_mask[k], ent_level[k], ent_dyn[k]},
            {29'h0, low_exp(k)[16], low_exp(k)[15], low_exp(k)[8]});
      check("R8 dest port", {24'h0, ent_dest[k*8 +: 8]}, {24'h0, dst_exp(k)});
    end

    // R9: unmapped indices
    for (int i = 3; i < 256; i++) begin
      if (i >= 16 && i < 48) continue;
      set_idx(8'(i)); check("R9 unmapped read", win_rdata, 32'h0);
      wr(32'hFFFF_FFFF);
    end
    check("R9 vector intact", ent_vector[31:0], {low_exp(3)[7:0], low_exp(2)[7:0], low_exp(1)[7:0], low_exp(0)[7:0]});
    check("R9 dest intact", ent_dest[31:0], {dst_exp(3), dst_exp(2), dst_exp(1), dst_exp(0)});
    check("R9 arb intact", {28'h0, arb_id}, 32'hF);
    rd_at(8'h00, r); check("R9 id intact", r, 32'h0F00_0000);
    rd_at(8'h2F, r); check("R9 last high intact", r, {dst_exp(15), 24'h0});

    // R10: index and window written in the same cycle (index is 0x2F now)
    set_idx(8'h00);
    @(negedge clk); sel_we = 1'b1; sel_wdata = 8'h02; win_we = 1'b1; win_wdata = 32'h0500_0000;
    @(negedge clk); sel_we = 1'b0; win_we = 1'b0;
    check("R10 new index", {24'h0, cur_index}, 32'h02);
    check("R10 arb from old index", win_rdata, 32'h0500_0000);
    rd_at(8'h00, r); check("R10 id from old index", r, 32'h0500_0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule